// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer reached through a simple 32-bit register port (valid, write, address, write data, combinational read data). Software picks a timeout with a 4-bit interval code, sets the enable bit, and must keep restarting the timer before it runs out. A restart counts only if the control write carries a 12-bit unlock key. A prescaler divides the system clock into a half-second tick, and the counter steps down once per tick. When the count runs out, a one-cycle reset pulse is sent, but only if both the watchdog enable and the reset enable are set.

The sequencing lives in a small state machine with four named states. IDLE is the state after reset, before any reload. RUN counts ticks. FIRE lasts exactly one cycle and drives the pulse when both enables are set. HALT holds the counter at zero until the next reload. The transitions are: any state goes to RUN on a reload (reload has priority); RUN goes to FIRE on a tick that takes the count from one or zero to zero; FIRE always goes to HALT. A parameter selects an older register layout with no key. Both interrupt registers are plain storage.

Top module: `wdog_top`

## Requirements
- R1: After reset every register reads zero, `wdog_rst` is low and `code_err` is low.
- R2: With the keyed layout, the registers sit at these offsets: interrupt enable 0x00, interrupt status 0x04, control 0x10, config 0x14 and mode 0x18. Interrupt enable, interrupt status, config and mode read back the last full word written to them. Control reads zero. Any other offset reads zero and ignores writes.
- R3: A control write with bit 0 set and bits [12:1] equal to 0xA57 reloads the counter. A control write with any other key value has no effect.
- R4: A mode write that takes mode bit 0 (enable) from 0 to 1 reloads the counter from the written code in mode bits [7:4]. Writing bit 0 as 1 while it is already 1 does not reload.
- R5: Codes 0 to 11 give these timeouts in half-second units: 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32. A reload clears the prescaler, so the pulse appears exactly units×CLK_HZ/2 cycles after the reload edge.
- R6: A reload with a code of 12 or above leaves the count unchanged and sets `code_err`, but the timer still restarts from a cleared prescaler. A later reload with a valid code clears `code_err`.
- R7: The pulse lasts exactly one cycle. It appears only if mode bit 0 and config bit 0 (reset enable) are both set. Otherwise the expiry is dropped.
- R8: After an expiry the timer stays halted at zero and never fires again on its own. This holds even if the reset enable is set afterwards.
- R9: If a reload falls in the same cycle as the tick that would end the count, the reload wins and no pulse is produced.
- R10: With LEGACY=1, control is at 0x00 and mode is at 0x04. A restart needs only control bit 0. The reset enable is mode bit 1, and the code is in mode bits [6:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is strobed |
| wdog_rst | output | 1 | One-cycle system reset request |
| code_err | output | 1 | Last reload used an out-of-range interval code |

## Verification
The restart write and the final prescaler tick can land on the same clock edge. The bench makes this happen with code 0, which gives a one-tick timeout. It enables the timer, idles three cycles, and then issues a keyed restart so that the restart is sampled on the very edge where the count would hit zero. The result passes only if `wdog_rst` stays low after that edge and the pulse comes exactly one full tick period later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIRE,
        ST_HALT
    } wd_state_t;

    localparam logic [11:0] UNLOCK_KEY = 12'hA57;
    localparam int          NUM_CODES  = 12;
    localparam int          UNIT_W     = 6;

    typedef struct packed {
        logic       en;
        logic       rst_en;
        logic [3:0] code;
    } wd_ctl_t;

    function automatic logic [UNIT_W-1:0] code_units(input logic [3:0] c);
        case (c)
            4'd0:    code_units = 6'd1;
            4'd1:    code_units = 6'd2;
            4'd2:    code_units = 6'd4;
            4'd3:    code_units = 6'd6;
            4'd4:    code_units = 6'd8;
            4'd5:    code_units = 6'd10;
            4'd6:    code_units = 6'd12;
            4'd7:    code_units = 6'd16;
            4'd8:    code_units = 6'd20;
            4'd9:    code_units = 6'd24;
            4'd10:   code_units = 6'd28;
            4'd11:   code_units = 6'd32;
            default: code_units = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int AW     = 8,
    parameter bit LEGACY = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output wd_ctl_t       ctl,
    output logic          reload,
    output logic [3:0]    reload_code
);

    localparam logic [AW-1:0] OFS_IEN  = AW'(8'h00);
    localparam logic [AW-1:0] OFS_ISTA = AW'(8'h04);
    localparam logic [AW-1:0] OFS_CTRL = LEGACY ? AW'(8'h00) : AW'(8'h10);
    localparam logic [AW-1:0] OFS_CFG  = AW'(8'h14);
    localparam logic [AW-1:0] OFS_MODE = LEGACY ? AW'(8'h04) : AW'(8'h18);

    logic [31:0] r_ien, r_ista, r_cfg, r_mode;
    logic        wr, hit_ien, hit_ista, hit_ctrl, hit_cfg, hit_mode;
    logic        key_ok, restart, en_edge;
    logic [3:0]  code_wr, code_st;
    logic        rsten_st;

    assign wr       = bus_valid && bus_write;
    assign hit_ctrl = (bus_addr == OFS_CTRL);
    assign hit_mode = (bus_addr == OFS_MODE);

    generate
        if (LEGACY) begin : g_legacy
            assign hit_ien  = 1'b0;
            assign hit_ista = 1'b0;
            assign hit_cfg  = 1'b0;
            assign key_ok   = 1'b1;
            assign code_wr  = bus_wdata[6:3];
            assign code_st  = r_mode[6:3];
            assign rsten_st = r_mode[1];
        end else begin : g_keyed
            assign hit_ien  = (bus_addr == OFS_IEN);
            assign hit_ista = (bus_addr == OFS_ISTA);
            assign hit_cfg  = (bus_addr == OFS_CFG);
            assign key_ok   = (bus_wdata[12:1] == UNLOCK_KEY);
            assign code_wr  = bus_wdata[7:4];
            assign code_st  = r_mode[7:4];
            assign rsten_st = r_cfg[0];
        end
    endgenerate

    assign restart     = wr && hit_ctrl && bus_wdata[0] && key_ok;
    assign en_edge     = wr && hit_mode && bus_wdata[0] && !r_mode[0];
    assign reload      = restart || en_edge;
    assign reload_code = (wr && hit_mode) ? code_wr : code_st;

    assign ctl.en     = r_mode[0];
    assign ctl.rst_en = rsten_st;
    assign ctl.code   = code_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_ien  <= '0;
            r_ista <= '0;
            r_cfg  <= '0;
            r_mode <= '0;
        end else if (wr) begin
            if (hit_ien)  r_ien  <= bus_wdata;
            if (hit_ista) r_ista <= bus_wdata;
            if (hit_cfg)  r_cfg  <= bus_wdata;
            if (hit_mode) r_mode <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (hit_mode)      bus_rdata = r_mode;
            else if (hit_ctrl) bus_rdata = '0;
            else if (hit_ien)  bus_rdata = r_ien;
            else if (hit_ista) bus_rdata = r_ista;
            else if (hit_cfg)  bus_rdata = r_cfg;
        end
    end

    // R3: a keyed-layout control write with a wrong key never reloads
    p_badkey_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEGACY && wr && hit_ctrl && bus_wdata[12:1] != UNLOCK_KEY && !hit_mode) |-> !reload);

    // R2: mode only changes on a write that decodes to it
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit_mode) |=> $stable(r_mode));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int CLK_HZ = 24_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int HALF = (CLK_HZ / 2 > 1) ? CLK_HZ / 2 : 2;
    localparam int PW   = $clog2(HALF);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) pcnt <= '0;
        else if (tick)     pcnt <= '0;
        else               pcnt <= pcnt + 1'b1;
    end

    // R5: a cleared prescaler needs a full period before its next tick
    p_clr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);

    p_tick_sparse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reload,
    input  logic [3:0] reload_code,
    input  wd_ctl_t    ctl,
    output logic       rst_pulse,
    output logic       code_err
);

    wd_state_t         state, st_n;
    logic [UNIT_W-1:0] cnt, cnt_n;
    logic              err_n;

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        err_n = code_err;
        if (reload) begin
            st_n = ST_RUN;
            if (reload_code < 4'(NUM_CODES)) begin
                cnt_n = code_units(reload_code);
                err_n = 1'b0;
            end else begin
                err_n = 1'b1;
            end
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RUN: begin
                    if (tick) begin
                        if (cnt <= UNIT_W'(1)) begin
                            cnt_n = '0;
                            st_n  = ST_FIRE;
                        end else begin
                            cnt_n = cnt - 1'b1;
                        end
                    end
                end
                ST_FIRE: st_n = ST_HALT;
                ST_HALT: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            code_err <= 1'b0;
        end else begin
            state    <= st_n;
            cnt      <= cnt_n;
            code_err <= err_n;
        end
    end

    always_comb begin
        rst_pulse = (state == ST_FIRE) && ctl.en && ctl.rst_en;
    end

    // R7: the reset request never lasts two cycles
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R8: once halted, only a reload moves the timer
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !reload) |=> (state == ST_HALT && cnt == '0));

    // R9: a reload always lands in RUN, whatever the tick does
    p_reload_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> state == ST_RUN);

    // R5: without a reload the count only goes down
    p_count_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && state == ST_RUN) |=> cnt <= $past(cnt));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CLK_HZ = 24_000_000,
    parameter bit LEGACY = 1'b0,
    parameter int AW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          wdog_rst,
    output logic          code_err
);

    wd_ctl_t    ctl;
    logic       reload;
    logic [3:0] reload_code;
    logic       tick;

    wdog_regs #(.AW(AW), .LEGACY(LEGACY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ctl        (ctl),
        .reload     (reload),
        .reload_code(reload_code)
    );

    wdog_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (reload),
        .tick (tick)
    );

    wdog_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .reload     (reload),
        .reload_code(reload_code),
        .ctl        (ctl),
        .rst_pulse  (wdog_rst),
        .code_err   (code_err)
    );

endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;

    localparam int CLK_PERIOD = 10;
    localparam int SIM_HZ     = 8;
    localparam int HALF       = SIM_HZ / 2;
    localparam int NVEC       = 12;
    localparam int EXP_UNITS [NVEC] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32};
    localparam logic [31:0] GOOD_KICK = 32'h0000_14AF;
    localparam logic [31:0] BAD_KICK  = 32'h0000_14AD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        k_valid = 1'b0, l_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] k_rdata, l_rdata;
    logic        k_rst, l_rst, k_err, l_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_top #(.CLK_HZ(SIM_HZ), .LEGACY(1'b0), .AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(k_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(k_rdata),
        .wdog_rst(k_rst), .code_err(k_err)
    );

    wdog_top #(.CLK_HZ(SIM_HZ), .LEGACY(1'b1), .AW(8)) dut_leg (
        .clk(clk), .rst_n(rst_n), .bus_valid(l_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(l_rdata),
        .wdog_rst(l_rst), .code_err(l_err)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input bit leg, input logic [7:0] a, input logic [31:0] d);
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        if (leg) l_valid = 1'b1; else k_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        k_valid   = 1'b0;
        l_valid   = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_write = 1'b0;
        bus_addr  = a;
        k_valid   = 1'b1;
        #1;
        d = k_rdata;
        k_valid = 1'b0;
    endtask

    task automatic wait_pulse(input bit leg, input int max, output int cyc);
        cyc = -1;
        for (int i = 1; i <= max; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (leg ? l_rst : k_rst) begin
                cyc = i;
                return;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rst", k_rst, 0);
        check("R1 err", k_err, 0);
        rd(8'h00, d); check("R1 ien", d, 0);
        rd(8'h14, d); check("R1 cfg", d, 0);
        rd(8'h18, d); check("R1 mode", d, 0);
        @(negedge clk);

        // R2: register map
        wr(0, 8'h00, 32'hDEAD_BEEF); rd(8'h00, d); check("R2 ien", d, 32'hDEAD_BEEF);
        @(negedge clk);
        wr(0, 8'h04, 32'h1234_5678); rd(8'h04, d); check("R2 ista", d, 32'h1234_5678);
        @(negedge clk);
        wr(0, 8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R2 unmapped", d, 0);
        @(negedge clk);
        rd(8'h10, d); check("R2 ctrl reads 0", d, 0);
        @(negedge clk);

        // R5: interval table, walked by one loop
        wr(0, 8'h14, 32'h1);
        for (int v = 0; v < NVEC; v++) begin
            wr(0, 8'h18, 32'h0);
            wr(0, 8'h18, 32'(v << 4) | 32'h1);
            wait_pulse(0, 200, cyc);
            check($sformatf("R5 code %0d", v), cyc, EXP_UNITS[v] * HALF);
            idle(1);
            check("R7 one cycle", k_rst, 0);
        end

        // R3: good key extends the timeout
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h21);
        idle(5);
        wr(0, 8'h10, GOOD_KICK);
        wait_pulse(0, 100, cyc);
        check("R3 good key", cyc, 16);

        // R3: wrong key is ignored
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h21);
        idle(5);
        wr(0, 8'h10, BAD_KICK);
        wait_pulse(0, 100, cyc);
        check("R3 bad key", cyc, 10);

        // R4: rewriting enable while set does not reload
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h21);
        idle(5);
        wr(0, 8'h18, 32'h51);
        wait_pulse(0, 100, cyc);
        check("R4 no reload", cyc, 10);
        rd(8'h18, d); check("R2 mode readback", d, 32'h51);
        @(negedge clk);

        // R6: out-of-range code keeps count, restarts prescaler
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h31);
        idle(7);
        wr(0, 8'h18, 32'hD1);
        wr(0, 8'h10, GOOD_KICK);
        check("R6 err set", k_err, 1);
        wait_pulse(0, 100, cyc);
        check("R6 kept count", cyc, 16);
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h11);
        check("R6 err cleared", k_err, 0);

        // R9: restart on the final tick edge wins
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h01);
        idle(3);
        wr(0, 8'h10, GOOD_KICK);
        check("R9 no pulse at tick", k_rst, 0);
        wait_pulse(0, 100, cyc);
        check("R9 fresh period", cyc, 4);

        // R7: no reset enable, then R8: no refire after enabling it
        wr(0, 8'h14, 32'h0);
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h01);
        wait_pulse(0, 12, cyc);
        check("R7 rst_en low", cyc, -1);
        wr(0, 8'h14, 32'h1);
        wait_pulse(0, 20, cyc);
        check("R8 no refire", cyc, -1);

        // R7: mode enable low, keyed restart still runs, expiry dropped
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h10, GOOD_KICK);
        wait_pulse(0, 12, cyc);
        check("R7 en low", cyc, -1);

        // R10: legacy layout
        wr(1, 8'h04, 32'h0B);
        wait_pulse(1, 100, cyc);
        check("R10 legacy timeout", cyc, 8);
        wr(1, 8'h00, 32'h1);
        wait_pulse(1, 100, cyc);
        check("R10 legacy restart", cyc, 8);
        check("R10 keyed untouched", k_rst, 0);

        // R1: reset mid-run clears everything
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h31);
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(8'h18, d); check("R1 mode after reset", d, 0);
        @(negedge clk);
        wait_pulse(0, 40, cyc);
        check("R1 quiet after reset", cyc, -1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule